// File: doc/BRIEF.md
# Byte-Granular Region Conflict Checker

This block keeps per-byte access metadata for a small set of cache lines and judges every load and store against it before the access may complete. Each line holds four byte masks. Two record what the local thread has read and written inside its current region. Two record what other threads have read and written inside their still-active regions. A request whose bytes collide with a peer's active region is denied, which raises a precise conflict exception. A request that is not denied completes, and inside a region it marks its bytes in the local masks.

The coherence side feeds the block in three ways. Peer bits arrive with a miss fill and are merged into the remote masks. End-of-region notices from peers clear remote bits. A supply mark records that a line was handed to another cache. The local region ends with a single pulse that wipes the local masks and the supply marks. When a notice removes remote read bits from a line that the local cache holds exclusively, a downgrade request is raised. A snoop port shows the local masks of any line, so that the coherence side can attach them to replies.

Top module: `byte_conflict_guard`

## Requirements
- R1: A read is denied when any enabled byte (bit i of `acc_be` is byte i of the line) has its remote write bit set and its local write bit clear.
- R2: A write is denied when any enabled byte has its remote read bit set, or has its remote write bit set while its local write bit is clear.
- R3: A request that is not denied, made while `in_region` is high and `acc_singleton` is low, sets the local read bits (read) or local write bits (write) of its enabled bytes. A denied request changes no bit.
- R4: When `acc_singleton` is high or `in_region` is low, the request is still checked by R1 and R2, but it sets no local bit.
- R5: A fill ORs `fill_rd` into the remote read mask. It ORs `fill_wr` into the remote write mask, except for bytes whose local write bit is already set; those remote write bits stay clear.
- R6: A `region_end` pulse clears every local read bit, every local write bit and every supply mark at one edge. The remote masks are kept.
- R7: A notice clears each remote read bit selected by `ntc_rd` and each remote write bit selected by `ntc_wr`. If at least one set remote read bit is cleared while `ntc_excl` is high, `dgrd_valid` is high one cycle later, with `dgrd_line` set to the notice's line.
- R8: `rsp_valid` is high exactly in the cycle after a request is accepted (`acc_valid` and `acc_ready` both high). `rsp_deny` is 1 for a denied request and is never high without `rsp_valid`.
- R9: `acc_ready` is low in any cycle where `fill_valid`, `ntc_valid` or `region_end` is high, and high otherwise.
- R10: `sup_valid` sets the supply bit of `sup_line` (bit n of `supplied_map` is line n). If `region_end` comes in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_region | input | 1 | Local thread is inside an explicit region |
| region_end | input | 1 | One-cycle pulse that closes the local region |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Request can be taken this cycle |
| acc_line | input | IW | Line index of the request |
| acc_be | input | LINE_BYTES | Bytes touched by the request |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_singleton | input | 1 | Request lies outside any explicit region |
| rsp_valid | output | 1 | Verdict of the request accepted in the previous cycle |
| rsp_deny | output | 1 | Conflict exception for that request |
| fill_valid | input | 1 | Miss fill carrying peer bits |
| fill_line | input | IW | Line being filled |
| fill_rd | input | LINE_BYTES | Peer read bits |
| fill_wr | input | LINE_BYTES | Peer write bits |
| ntc_valid | input | 1 | End-of-region notice from a peer |
| ntc_line | input | IW | Line named in the notice |
| ntc_rd | input | LINE_BYTES | Remote read bits to clear |
| ntc_wr | input | LINE_BYTES | Remote write bits to clear |
| ntc_excl | input | 1 | Line is held in an exclusive (M or E) state |
| dgrd_valid | output | 1 | Line must drop to a shared (O or S) state |
| dgrd_line | output | IW | Line to downgrade |
| sup_valid | input | 1 | Line was supplied to a peer |
| sup_line | input | IW | Supplied line |
| supplied_map | output | LINES | Per-line supply marks |
| snp_line | input | IW | Line whose local masks are shown |
| snp_lrd | output | LINE_BYTES | Local read mask of `snp_line` |
| snp_lwr | output | LINE_BYTES | Local write mask of `snp_line` |

## Verification
The properties assume that `region_end` and notices arrive as single-cycle strobes, and that every line index is below `LINES`. The driver holds each strobe for one cycle and only uses indices 0 to 3. The request channel is only driven while no fill, notice or end pulse is pending, so every request is taken in the cycle it is offered. This lets each scoreboard entry map to exactly one response, one cycle later.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bcg_line_meta.sv
module bcg_line_meta #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_lrd,
  input  logic [NB-1:0] set_lwr,
  input  logic          merge_en,
  input  logic [NB-1:0] merge_rd,
  input  logic [NB-1:0] merge_wr,
  input  logic          wipe_en,
  input  logic [NB-1:0] wipe_rd,
  input  logic [NB-1:0] wipe_wr,
  input  logic          local_clr,
  input  logic          sup_set,
  output logic [NB-1:0] lrd,
  output logic [NB-1:0] lwr,
  output logic [NB-1:0] rrd,
  output logic [NB-1:0] rwr,
  output logic          sup
);

  logic [NB-1:0] rrd_merged, rwr_merged;
  logic [NB-1:0] rrd_next, rwr_next;

  always_comb begin
    rrd_merged = rrd;
    rwr_merged = rwr;
    if (merge_en) begin
      rrd_merged = rrd | merge_rd;
      rwr_merged = rwr | (merge_wr & ~lwr);
    end
    rrd_next = rrd_merged;
    rwr_next = rwr_merged;
    if (wipe_en) begin
      rrd_next = rrd_merged & ~wipe_rd;
      rwr_next = rwr_merged & ~wipe_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrd <= '0;
      lwr <= '0;
      rrd <= '0;
      rwr <= '0;
      sup <= 1'b0;
    end else begin
      rrd <= rrd_next;
      rwr <= rwr_next;
      if (local_clr) begin
        lrd <= '0;
        lwr <= '0;
        sup <= 1'b0;
      end else begin
        lrd <= lrd | set_lrd;
        lwr <= lwr | set_lwr;
        sup <= sup | sup_set;
      end
    end
  end

endmodule

// File: rtl/bcg_conflict_eval.sv
module bcg_conflict_eval #(
  parameter int unsigned NB = 4
) (
  input  logic [NB-1:0] be,
  input  logic          is_store,
  input  logic [NB-1:0] lwr,
  input  logic [NB-1:0] rrd,
  input  logic [NB-1:0] rwr,
  output logic [NB-1:0] clash,
  output logic          deny
);

  logic [NB-1:0] foreign_wr;

  always_comb begin
    foreign_wr = rwr & ~lwr;
    if (is_store) clash = be & (foreign_wr | rrd);
    else          clash = be & foreign_wr;
    deny = |clash;
  end

endmodule

// File: rtl/byte_conflict_guard.sv
module byte_conflict_guard
  import bcg_pkg::*;
#(
  parameter int unsigned LINES      = 4,
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned IW        = idx_width(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_region,
  input  logic                  region_end,
  input  logic                  acc_valid,
  output logic                  acc_ready,
  input  logic [IW-1:0]         acc_line,
  input  logic [LINE_BYTES-1:0] acc_be,
  input  logic                  acc_write,
  input  logic                  acc_singleton,
  output logic                  rsp_valid,
  output logic                  rsp_deny,
  input  logic                  fill_valid,
  input  logic [IW-1:0]         fill_line,
  input  logic [LINE_BYTES-1:0] fill_rd,
  input  logic [LINE_BYTES-1:0] fill_wr,
  input  logic                  ntc_valid,
  input  logic [IW-1:0]         ntc_line,
  input  logic [LINE_BYTES-1:0] ntc_rd,
  input  logic [LINE_BYTES-1:0] ntc_wr,
  input  logic                  ntc_excl,
  output logic                  dgrd_valid,
  output logic [IW-1:0]         dgrd_line,
  input  logic                  sup_valid,
  input  logic [IW-1:0]         sup_line,
  output logic [LINES-1:0]      supplied_map,
  input  logic [IW-1:0]         snp_line,
  output logic [LINE_BYTES-1:0] snp_lrd,
  output logic [LINE_BYTES-1:0] snp_lwr
);

  localparam int unsigned NB = LINE_BYTES;

  logic [NB-1:0] lrd_a [LINES];
  logic [NB-1:0] lwr_a [LINES];
  logic [NB-1:0] rrd_a [LINES];
  logic [NB-1:0] rwr_a [LINES];

  acc_kind_e     kind;
  logic          accept;
  logic          marks;
  logic [NB-1:0] clash;
  logic          deny;
  logic [NB-1:0] sel_lwr, sel_rrd, sel_rwr;
  logic [NB-1:0] ntc_rrd_now;
  logic          dgrd_hit;

  assign kind      = acc_kind_e'(acc_write);
  assign acc_ready = ~(fill_valid | ntc_valid | region_end);
  assign accept    = acc_valid & acc_ready;
  assign marks     = accept & ~deny & in_region & ~acc_singleton;

  assign sel_lwr = lwr_a[acc_line];
  assign sel_rrd = rrd_a[acc_line];
  assign sel_rwr = rwr_a[acc_line];

  bcg_conflict_eval #(.NB(NB)) u_eval (
    .be       (acc_be),
    .is_store (kind == ACC_STORE),
    .lwr      (sel_lwr),
    .rrd      (sel_rrd),
    .rwr      (sel_rwr),
    .clash    (clash),
    .deny     (deny)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_acc, hit_fill, hit_ntc, hit_sup;
    assign hit_acc  = marks && (acc_line == IW'(g));
    assign hit_fill = fill_valid && (fill_line == IW'(g));
    assign hit_ntc  = ntc_valid && (ntc_line == IW'(g));
    assign hit_sup  = sup_valid && (sup_line == IW'(g));

    bcg_line_meta #(.NB(NB)) u_meta (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_lrd   ((hit_acc && kind == ACC_LOAD)  ? acc_be : '0),
      .set_lwr   ((hit_acc && kind == ACC_STORE) ? acc_be : '0),
      .merge_en  (hit_fill),
      .merge_rd  (fill_rd),
      .merge_wr  (fill_wr),
      .wipe_en   (hit_ntc),
      .wipe_rd   (ntc_rd),
      .wipe_wr   (ntc_wr),
      .local_clr (region_end),
      .sup_set   (hit_sup),
      .lrd       (lrd_a[g]),
      .lwr       (lwr_a[g]),
      .rrd       (rrd_a[g]),
      .rwr       (rwr_a[g]),
      .sup       (supplied_map[g])
    );
  end

  assign ntc_rrd_now = rrd_a[ntc_line];
  assign dgrd_hit    = ntc_valid & ntc_excl & (|(ntc_rrd_now & ntc_rd));

  assign snp_lrd = lrd_a[snp_line];
  assign snp_lwr = lwr_a[snp_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_deny   <= 1'b0;
      dgrd_valid <= 1'b0;
      dgrd_line  <= '0;
    end else begin
      rsp_valid  <= accept;
      rsp_deny   <= accept & deny;
      dgrd_valid <= dgrd_hit;
      if (dgrd_hit) dgrd_line <= ntc_line;
    end
  end

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int unsigned NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          rsp_valid,
  input logic          rsp_deny,
  input logic          region_end,
  input logic          ntc_valid,
  input logic          ntc_excl,
  input logic          dgrd_valid,
  input logic [3:0]    any_sup,
  input logic [NB-1:0] snp_lrd,
  input logic [NB-1:0] snp_lwr
);

  // R8
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && acc_ready));

  // R8
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> rsp_valid);

  // R8
  deny_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> rsp_valid);

  // R6
  end_wipes_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_end |=> (snp_lrd == '0 && snp_lwr == '0 && any_sup == '0));

  // R7
  dgrd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dgrd_valid |-> $past(ntc_valid && ntc_excl));

endmodule

bind byte_conflict_guard bcg_checker #(.NB(LINE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .rsp_valid  (rsp_valid),
  .rsp_deny   (rsp_deny),
  .region_end (region_end),
  .ntc_valid  (ntc_valid),
  .ntc_excl   (ntc_excl),
  .dgrd_valid (dgrd_valid),
  .any_sup    (4'(supplied_map)),
  .snp_lrd    (snp_lrd),
  .snp_lwr    (snp_lwr)
);

// File: tb/byte_conflict_guard_bench.sv
`timescale 1ns/1ps
module byte_conflict_guard_bench;

  localparam int LINES = 4;
  localparam int NB    = 4;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_region = 1'b0, region_end = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_singleton = 1'b0;
  logic [IW-1:0] acc_line = '0;
  logic [NB-1:0] acc_be = '0;
  logic acc_ready, rsp_valid, rsp_deny;
  logic fill_valid = 1'b0;
  logic [IW-1:0] fill_line = '0;
  logic [NB-1:0] fill_rd = '0, fill_wr = '0;
  logic ntc_valid = 1'b0, ntc_excl = 1'b0;
  logic [IW-1:0] ntc_line = '0;
  logic [NB-1:0] ntc_rd = '0, ntc_wr = '0;
  logic dgrd_valid;
  logic [IW-1:0] dgrd_line;
  logic sup_valid = 1'b0;
  logic [IW-1:0] sup_line = '0;
  logic [LINES-1:0] supplied_map;
  logic [IW-1:0] snp_line = '0;
  logic [NB-1:0] snp_lrd, snp_lwr;

  always #4 clk = ~clk;

  byte_conflict_guard #(.LINES(LINES), .LINE_BYTES(NB)) u_byte_conflict_guard (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the four masks and supply marks
  logic [NB-1:0] m_lrd [LINES];
  logic [NB-1:0] m_lwr [LINES];
  logic [NB-1:0] m_rrd [LINES];
  logic [NB-1:0] m_rwr [LINES];
  logic [LINES-1:0] m_sup;

  typedef struct { logic deny; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic model_deny(input int l, input logic [NB-1:0] be, input logic wr);
    logic [NB-1:0] fw;
    fw = m_rwr[l] & ~m_lwr[l];
    if (wr) return |(be & (fw | m_rrd[l]));
    return |(be & fw);
  endfunction

  // driver: one request, expected verdict into the scoreboard
  task automatic access(input int l, input logic [NB-1:0] be, input logic wr,
                        input logic sing, input string tag);
    exp_t e;
    @(negedge clk);
    e.deny = model_deny(l, be, wr);
    e.tag  = tag;
    if (!e.deny && in_region && !sing) begin
      if (wr) m_lwr[l] = m_lwr[l] | be;
      else    m_lrd[l] = m_lrd[l] | be;
    end
    exp_q.push_back(e);
    acc_valid = 1'b1; acc_line = IW'(l); acc_be = be;
    acc_write = wr; acc_singleton = sing;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_singleton = 1'b0;
  endtask

  // monitor: pop and compare verdicts
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected rsp", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rsp_deny, e.deny);
      end
    end
  end

  task automatic fill(input int l, input logic [NB-1:0] rd, input logic [NB-1:0] wr);
    @(negedge clk);
    fill_valid = 1'b1; fill_line = IW'(l); fill_rd = rd; fill_wr = wr;
    m_rrd[l] = m_rrd[l] | rd;
    m_rwr[l] = m_rwr[l] | (wr & ~m_lwr[l]);
    #1 check("R9 ready low during fill", acc_ready, 0);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic notice(input int l, input logic [NB-1:0] rd, input logic [NB-1:0] wr,
                        input logic excl, input string tag);
    logic exp_dg;
    @(negedge clk);
    exp_dg = excl && |(m_rrd[l] & rd);
    m_rrd[l] = m_rrd[l] & ~rd;
    m_rwr[l] = m_rwr[l] & ~wr;
    ntc_valid = 1'b1; ntc_line = IW'(l); ntc_rd = rd; ntc_wr = wr; ntc_excl = excl;
    @(posedge clk); #1;
    ntc_valid = 1'b0; ntc_excl = 1'b0;
    @(negedge clk);
    check(tag, dgrd_valid, exp_dg);
    if (exp_dg) check({tag, " line"}, dgrd_line, l);
  endtask

  task automatic end_region(input logic with_sup, input int sl);
    @(negedge clk);
    region_end = 1'b1;
    if (with_sup) begin sup_valid = 1'b1; sup_line = IW'(sl); end
    #1 check("R9 ready low during end", acc_ready, 0);
    @(posedge clk); #1;
    region_end = 1'b0; sup_valid = 1'b0;
    for (int i = 0; i < LINES; i++) begin m_lrd[i] = '0; m_lwr[i] = '0; end
    m_sup = '0;
  endtask

  task automatic supply(input int l);
    @(negedge clk);
    sup_valid = 1'b1; sup_line = IW'(l);
    @(posedge clk); #1;
    sup_valid = 1'b0;
    m_sup[l] = 1'b1;
  endtask

  task automatic snoop(input int l, input string tag);
    @(negedge clk);
    snp_line = IW'(l);
    #1;
    check({tag, " lrd"}, snp_lrd, m_lrd[l]);
    check({tag, " lwr"}, snp_lwr, m_lwr[l]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_lrd[i] = '0; m_lwr[i] = '0; m_rrd[i] = '0; m_rwr[i] = '0;
    end
    m_sup = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("reset ready", acc_ready, 1);
    check("R8 reset rsp_valid", rsp_valid, 0);
    check("R7 reset dgrd", dgrd_valid, 0);
    check("R10 reset supply", supplied_map, 0);
    snoop(0, "R3 reset snoop");

    in_region = 1'b1;
    // R3: granted region read marks local read bits
    access(0, 4'b0011, 1'b0, 1'b0, "R3 read line0 grant");
    snoop(0, "R3 after read");

    // R1/R2 against peer bits on line1
    fill(1, 4'b0100, 4'b0001);
    access(1, 4'b0001, 1'b0, 1'b0, "R1 read vs remote write deny");
    access(1, 4'b0100, 1'b0, 1'b0, "R1 read vs remote read grant");
    access(1, 4'b0100, 1'b1, 1'b0, "R2 write vs remote read deny");
    access(1, 4'b1000, 1'b1, 1'b0, "R2 write clean byte grant");
    access(1, 4'b0001, 1'b1, 1'b0, "R2 write vs remote write deny");
    snoop(1, "R3 denied leave no bits");

    // R5: local write masks merge of peer write bits
    access(2, 4'b0010, 1'b1, 1'b0, "R3 write line2 grant");
    fill(2, 4'b0000, 4'b0011);
    access(2, 4'b0010, 1'b0, 1'b0, "R1 read own written byte grant");

    // R4: singleton and out-of-region accesses
    access(3, 4'b1111, 1'b1, 1'b1, "R4 singleton write grant");
    snoop(3, "R4 singleton leaves no bits");
    fill(3, 4'b1000, 4'b0000);
    access(3, 4'b1000, 1'b1, 1'b1, "R4 singleton still checked deny");
    in_region = 1'b0;
    access(0, 4'b0100, 1'b1, 1'b0, "R4 out of region write grant");
    snoop(0, "R4 out of region no bits");
    in_region = 1'b1;

    // R10 / R6
    supply(2);
    @(negedge clk);
    check("R10 supply mark", supplied_map, m_sup);
    end_region(1'b1, 1);
    @(negedge clk);
    check("R10 clear wins over supply", supplied_map, 0);
    snoop(0, "R6 cleared line0");
    snoop(1, "R6 cleared line1");
    snoop(2, "R6 cleared line2");

    // R5 visible now that local write is gone; R6 kept remote
    access(2, 4'b0010, 1'b0, 1'b0, "R5 masked remote write grant");
    access(2, 4'b0001, 1'b0, 1'b0, "R5 merged remote write deny");
    access(1, 4'b0001, 1'b0, 1'b0, "R6 remote write kept deny");

    // R7 notices
    notice(1, 4'b0100, 4'b0000, 1'b1, "R7 read clear exclusive downgrade");
    access(1, 4'b0001, 1'b0, 1'b0, "R7 remote write still set deny");
    notice(1, 4'b0000, 4'b0001, 1'b1, "R7 write-only clear no downgrade");
    access(1, 4'b0001, 1'b0, 1'b0, "R7 remote write cleared grant");
    access(1, 4'b0100, 1'b1, 1'b0, "R7 remote read cleared grant");
    notice(1, 4'b1000, 4'b0000, 1'b1, "R7 clear of unset bit no downgrade");
    notice(3, 4'b1000, 4'b0000, 1'b0, "R7 shared line no downgrade");
    access(3, 4'b1000, 1'b1, 1'b1, "R7 line3 read cleared grant");
    snoop(1, "R3 line1 after notices");

    @(negedge clk);
    @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule